// File: doc/BRIEF.md
# Three-Bank Interrupt Status Controller

This block gathers peripheral interrupt sources into three byte-wide banks and presents them to a processor. Two banks, A and B, feed the normal interrupt line. The third bank feeds the fast interrupt line. Each bank has three registers. The status register reflects the sources. The mask register is written by software. The request register returns status AND mask. A bank raises its line when its request value is nonzero.

Bank A mixes three kinds of bit:
- level sources, which show their input directly;
- two event bits, which latch on a rising edge of their source;
- a power-on flag, which is set by reset.

Its top bit always reads 1. Software clears the event bits and the power-on flag by writing a bit pattern to the bank A request offset. Bank B shows eight level sources. The fast bank shows three level sources, and its top bit always reads 1.

Software reaches the registers through a single-cycle register bus. A write takes effect on the clock edge. Read data is combinational from the offset.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset all three masks read 0x00, both event bits are clear, the power-on flag (bank A bit4) is set, and `irq_o` and `fiq_o` are low. Once cleared, the power-on flag stays clear until the next reset.
- R2: Bank A status at offset 0x10 is composed as follows:
  - bit7 is always 1;
  - bit6 and bit5 follow `a_lvl[3]` and `a_lvl[2]`;
  - bit4 is the power-on flag;
  - bit3 and bit2 are the event bits for `a_edge[1]` and `a_edge[0]`;
  - bit1 and bit0 follow `a_lvl[1]` and `a_lvl[0]`.
- R3: An event bit is set on the clock edge at which its `a_edge` source is sampled high after being sampled low. It stays set after the source falls.
- R4: A write to offset 0x14 clears the bits selected by `wdata`: bit2 clears event 0, bit3 clears event 1, and bit4 clears the power-on flag. Other `wdata` bits have no effect. A rising edge in the same cycle as its clear leaves the event bit set.
- R5: Bank B status at offset 0x20 equals `b_lvl` bit for bit.
- R6: Fast bank status at offset 0x30 is composed as follows:
  - bit0 follows `f_lvl[0]`;
  - bit4 follows `f_lvl[1]`;
  - bit6 follows `f_lvl[2]`;
  - bit7 is always 1;
  - bits 1, 2, 3 and 5 read 0.
- R7: The masks at offsets 0x18 (A), 0x28 (B) and 0x38 (fast) read back the full byte last written to them.
- R8: The request registers at offsets 0x14, 0x24 and 0x34 read the status of their bank ANDed with the mask of that bank.
- R9: `irq_o` is high exactly when the bank A or bank B request is nonzero. `fiq_o` is high exactly when the fast bank request is nonzero.
- R10: Reads from any other offset return 0x00. This includes offsets that are not word-aligned. Writes to status registers, to the B and fast request registers, and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, taken on the rising clock edge |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| a_lvl | input | 4 | Bank A level sources (status bits 0, 1, 5, 6) |
| a_edge | input | 2 | Bank A edge sources (status bits 2, 3) |
| b_lvl | input | 8 | Bank B level sources |
| f_lvl | input | 3 | Fast bank level sources (status bits 0, 4, 6) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A rising edge on a bank A event source can land in the same cycle as a software write to 0x14 that clears that same bit. The design must keep the new event rather than lose it.

The bench provokes this in two ways:
- a directed cycle raises `a_edge[1]` while writing 0x08 to 0x14;
- random cycles toggle the edge sources while writing random data to 0x14.

A bench model applies set-over-clear priority. The status, request and interrupt outputs are read back after every such cycle and compared with the model.

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [3:0]        a_lvl,
  input  logic [1:0]        a_edge,
  input  logic [7:0]        b_lvl,
  input  logic [2:0]        f_lvl,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [ADDR_W-1:0] OFS_SA = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_RA = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_MA = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_SB = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_RB = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] OFS_MB = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_SF = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] OFS_RF = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] OFS_MF = ADDR_W'('h38);

  logic [1:0] lat, edge_q;
  logic       por;
  logic [7:0] mask_a, mask_b, mask_f;
  logic [7:0] sts_a, sts_b, sts_f;
  logic [7:0] req_a, req_b, req_f;
  logic       clr_wr;

  assign clr_wr = wr_en && (addr == OFS_RA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat    <= '0;
      edge_q <= '0;
      por    <= 1'b1;
    end else begin
      edge_q <= a_edge;
      lat    <= (lat & ~({2{clr_wr}} & wdata[3:2])) | (a_edge & ~edge_q);
      if (clr_wr && wdata[4]) por <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a <= '0;
      mask_b <= '0;
      mask_f <= '0;
    end else if (wr_en) begin
      if (addr == OFS_MA) mask_a <= wdata;
      if (addr == OFS_MB) mask_b <= wdata;
      if (addr == OFS_MF) mask_f <= wdata;
    end
  end

  assign sts_a = {1'b1, a_lvl[3:2], por, lat, a_lvl[1:0]};
  assign sts_b = b_lvl;
  assign sts_f = {1'b1, f_lvl[2], 1'b0, f_lvl[1], 3'b000, f_lvl[0]};

  assign req_a = sts_a & mask_a;
  assign req_b = sts_b & mask_b;
  assign req_f = sts_f & mask_f;

  assign irq_o = |{req_a, req_b};
  assign fiq_o = |req_f;

  always_comb begin
    case (addr)
      OFS_SA:  rdata = sts_a;
      OFS_RA:  rdata = req_a;
      OFS_MA:  rdata = mask_a;
      OFS_SB:  rdata = sts_b;
      OFS_RB:  rdata = req_b;
      OFS_MB:  rdata = mask_b;
      OFS_SF:  rdata = sts_f;
      OFS_RF:  rdata = req_f;
      OFS_MF:  rdata = mask_f;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [1:0]        a_edge,
  input logic [1:0]        lat,
  input logic              por,
  input logic [7:0]        mask_a,
  input logic [7:0]        mask_b,
  input logic [7:0]        mask_f,
  input logic              irq_o,
  input logic              fiq_o
);
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_a != 8'h00 || mask_b != 8'h00));

  assert_fiq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (mask_f != 8'h00));

  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_edge[0]) |=> lat[0]);

  assert_hold_until_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat[0] && !(wr_en && addr == ADDR_W'('h14) && wdata[2])) |=> lat[0]);

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h18)) |=> (mask_a == $past(wdata)));

  assert_por_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !por |=> !por);

  assert_top_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'('h10)) |-> rdata[7]);
endmodule

bind irq_bank_ctrl irq_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .a_edge(a_edge), .lat(lat), .por(por),
  .mask_a(mask_a), .mask_b(mask_b), .mask_f(mask_f),
  .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/irq_bank_ctrl_tb.sv
`timescale 1ns/100ps
module irq_bank_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic [3:0] a_lvl = '0;
  logic [1:0] a_edge = '0;
  logic [7:0] b_lvl = '0;
  logic [2:0] f_lvl = '0;
  logic       irq_o, fiq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] m_lat, m_prev;
  logic       m_por;
  logic [7:0] m_ma, m_mb, m_mf;

  always #10 clk = ~clk;

  irq_bank_ctrl #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .a_lvl(a_lvl), .a_edge(a_edge), .b_lvl(b_lvl),
    .f_lvl(f_lvl), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [7:0] e_sa();
    return {1'b1, a_lvl[3:2], m_por, m_lat, a_lvl[1:0]};
  endfunction
  function automatic logic [7:0] e_sf();
    return {1'b1, f_lvl[2], 1'b0, f_lvl[1], 3'b000, f_lvl[0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [7:0] exp);
    addr = a;
    #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic check_all();
    rd(8'h10, "R2 status A", e_sa());
    rd(8'h14, "R8 request A", e_sa() & m_ma);
    rd(8'h18, "R7 mask A", m_ma);
    rd(8'h20, "R5 status B", b_lvl);
    rd(8'h24, "R8 request B", b_lvl & m_mb);
    rd(8'h28, "R7 mask B", m_mb);
    rd(8'h30, "R6 status F", e_sf());
    rd(8'h34, "R8 request F", e_sf() & m_mf);
    rd(8'h38, "R7 mask F", m_mf);
    rd(8'h3c, "R10 unmapped read", 8'h00);
    chk("R9 irq", {7'd0, irq_o}, {7'd0, |(e_sa() & m_ma) | |(b_lvl & m_mb)});
    chk("R9 fiq", {7'd0, fiq_o}, {7'd0, |(e_sf() & m_mf)});
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [7:0] d,
                     input logic [3:0] al, input logic [1:0] ae,
                     input logic [7:0] bl, input logic [2:0] fl);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    a_lvl = al; a_edge = ae; b_lvl = bl; f_lvl = fl;
    @(posedge clk);
    begin
      logic [1:0] clr;
      clr = (w && a == 8'h14) ? d[3:2] : 2'b00;
      m_lat = (m_lat & ~clr) | (ae & ~m_prev);
      m_prev = ae;
      if (w && a == 8'h14 && d[4]) m_por = 1'b0;
      if (w && a == 8'h18) m_ma = d;
      if (w && a == 8'h28) m_mb = d;
      if (w && a == 8'h38) m_mf = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check_all();
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] wa [12];
    void'($urandom(32'h1d5e));
    wa = '{8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28,
           8'h30, 8'h34, 8'h38, 8'h3c, 8'h12, 8'h00};
    m_lat = '0; m_prev = '0; m_por = 1'b1; m_ma = '0; m_mb = '0; m_mf = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, "R1 reset status A", 8'h90);
    rd(8'h18, "R1 reset mask A", 8'h00);
    rd(8'h28, "R1 reset mask B", 8'h00);
    rd(8'h38, "R1 reset mask F", 8'h00);
    rd(8'h30, "R1 reset status F", 8'h80);
    chk("R1 reset irq/fiq", {6'd0, irq_o, fiq_o}, 8'h00);

    cyc(1, 8'h18, 8'h04, 4'h0, 2'b01, 8'h00, 3'b000);
    cyc(0, 8'h00, 8'h00, 4'h0, 2'b00, 8'h00, 3'b000);
    rd(8'h10, "R3 event held after fall", 8'h94);
    chk("R9 irq from held event", {7'd0, irq_o}, 8'h01);
    cyc(1, 8'h14, 8'h08, 4'h0, 2'b10, 8'h00, 3'b000);
    rd(8'h10, "R4 set wins over clear", 8'h9c);
    cyc(1, 8'h14, 8'hE3, 4'h0, 2'b00, 8'h00, 3'b000);
    rd(8'h10, "R4 other bits ignored", 8'h9c);
    cyc(1, 8'h14, 8'h1c, 4'h0, 2'b00, 8'h00, 3'b000);
    rd(8'h10, "R4 clear all", 8'h80);
    cyc(1, 8'h10, 8'hff, 4'h0, 2'b00, 8'h00, 3'b000);
    cyc(1, 8'h3c, 8'hff, 4'h0, 2'b00, 8'h00, 3'b000);
    cyc(1, 8'h1a, 8'hff, 4'h0, 2'b00, 8'h00, 3'b000);
    rd(8'h18, "R10 ignored writes", 8'h04);
    cyc(1, 8'h38, 8'h80, 4'h0, 2'b00, 8'h00, 3'b000);
    chk("R9 fiq from fixed bit", {7'd0, fiq_o}, 8'h01);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = wa[$urandom_range(0, 11)];
      cyc($urandom_range(0, 3) != 0, a, 8'($urandom), 4'($urandom),
          2'($urandom), 8'($urandom), 3'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule